// File: doc/BRIEF.md
# Locked Indirect Test-Register Bridge

This block sits behind a small directly addressed register file, such as the management register space of an Ethernet PHY, and opens a window onto four hidden banks of 16-bit test registers. Software reaches the hidden banks through four direct registers: a control register, a write-data register and two read-data registers (low and high). Every control write carries a test-mode bit, a bank number, and separate read and write addresses.

The hidden banks are locked after reset. Software opens them by writing the control register four times in a row with the test-mode bit set to 0, 1, 0 and then 1. After that, a control write with the write bit set stores the write-data register into the selected bank at the write address. A control write with the read bit set loads the addressed hidden register into the read-data registers. The window stays open until reset, or until a control write clears test-mode. Each hidden write also drives a single-cycle strobe with its bank, address and data on an output port, so that neighbouring analog or test logic can pick up the new value.

Top module: `tstreg_bridge`

## Requirements
- R1: The direct register file is addressed by reg_addr_i: control at 0x14, read-data low at 0x15, read-data high at 0x16, write-data at 0x17. A read of the control register returns the last value written to it, with bits 15 and 14 forced to 0. The write-data register returns what was written. Direct writes to 0x15 and 0x16 do not change them. Every other address reads 0.
- R2: The hidden banks open only after four consecutive control writes whose bit 10 (test-mode) reads 0, 1, 0, 1 in that order. A test-mode 0 that breaks the pattern counts as the first step of a new attempt. A test-mode 1 that breaks it restarts from the beginning.
- R3: Once open, the banks stay open through any number of writes until reset, or until a control write has bit 10 equal to 0. That write closes them and counts as the first step of a new unlock attempt.
- R4: Bits 12:11 of the control word select the bank and bits 4:0 select the write address. A control write with bit 14 set, made while the banks are already open, stores the write-data register into that bank location. In the same cycle, hid_we_o pulses with that bank, address and data.
- R5: Bits 9:5 of the control word select the read address. A control write with bit 15 set, made while the banks are open, copies the addressed hidden register into read-data low and sets read-data high to 0. The new values are visible from the cycle after the command.
- R6: A read or write command has no effect on the hidden banks or the read-data registers if the banks are locked when it arrives, or if its own bit 10 is 0. This includes the fourth write of the unlock sequence.
- R7: While the unlock sequence is in progress, a direct write to any address other than 0x14 resets the sequence to its start.
- R8: If a command has both bit 15 and bit 14 set, the write is performed and the read-data registers keep their values.
- R9: Each of the four banks holds 32 independent 16-bit locations. The same address in different banks holds different data.
- R10: Reset clears the direct registers and all hidden locations to 0 and locks the banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 5 | Direct register address |
| reg_wdata_i | input | 16 | Direct register write data |
| reg_we_i | input | 1 | Direct register write strobe |
| reg_rdata_o | output | 16 | Direct register read data (combinational on reg_addr_i) |
| hid_we_o | output | 1 | Hidden write strobe |
| hid_bank_o | output | 2 | Bank of the hidden write |
| hid_addr_o | output | 5 | Address of the hidden write |
| hid_wdata_o | output | 16 | Data of the hidden write |

## Verification
A wrong unlock state is seen at the ports at the first command that follows it. If the tracker is too permissive, hid_we_o pulses in the same cycle as the command. If it is too strict, the pulse that should appear is missing, and a later read-back shows the stale value one cycle after the read command. A write that reaches the wrong bank or address is seen only when that location, or the location it overwrote, is read back. The bench therefore reads every written location in every bank. A read that updates read-data low too early or too late shows up at 0x15 one cycle after the command.

// File: rtl/tstreg_pkg.sv
package tstreg_pkg;
  localparam int DW      = 16;
  localparam int REG_AW  = 5;
  localparam int BANK_AW = 5;
  localparam int NBANK   = 4;
  localparam int BANK_W  = $clog2(NBANK);

  localparam logic [REG_AW-1:0] A_CTRL = 5'h14;
  localparam logic [REG_AW-1:0] A_RDLO = 5'h15;
  localparam logic [REG_AW-1:0] A_RDHI = 5'h16;
  localparam logic [REG_AW-1:0] A_WDAT = 5'h17;

  // control word layout, bit 13 unused
  typedef struct packed {
    logic               rd;
    logic               wr;
    logic               spare;
    logic [BANK_W-1:0]  bank;
    logic               tm;
    logic [BANK_AW-1:0] raddr;
    logic [BANK_AW-1:0] waddr;
  } cmd_t;

  localparam logic [DW-1:0] CTRL_KEEP = 16'h3fff;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_S0,
    SEQ_S01,
    SEQ_S010,
    SEQ_OPEN
  } seq_e;
endpackage

// File: rtl/tstreg_unlock.sv
module tstreg_unlock
  import tstreg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_we_i,
  input  logic other_we_i,
  input  logic tm_i,
  output logic open_o,
  output seq_e state_o
);
  seq_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (ctrl_we_i) begin
      unique case (state_q)
        SEQ_IDLE: state_d = tm_i ? SEQ_IDLE : SEQ_S0;
        SEQ_S0:   state_d = tm_i ? SEQ_S01  : SEQ_S0;
        SEQ_S01:  state_d = tm_i ? SEQ_IDLE : SEQ_S010;
        SEQ_S010: state_d = tm_i ? SEQ_OPEN : SEQ_S0;
        SEQ_OPEN: state_d = tm_i ? SEQ_OPEN : SEQ_S0;
        default:  state_d = SEQ_IDLE;
      endcase
    end else if (other_we_i && state_q != SEQ_OPEN) begin
      state_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assign open_o  = (state_q == SEQ_OPEN);
  assign state_o = state_q;
endmodule

// File: rtl/tstreg_decode.sv
module tstreg_decode
  import tstreg_pkg::*;
(
  input  logic               ctrl_we_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               open_i,
  output logic               do_wr_o,
  output logic               do_rd_o,
  output logic [BANK_W-1:0]  bank_o,
  output logic [BANK_AW-1:0] waddr_o,
  output logic [BANK_AW-1:0] raddr_o
);
  cmd_t cmd;
  logic valid;

  assign cmd     = cmd_t'(wdata_i);
  assign valid   = ctrl_we_i & open_i & cmd.tm;
  assign do_wr_o = valid & cmd.wr;
  // write wins when both request bits are set
  assign do_rd_o = valid & cmd.rd & ~cmd.wr;
  assign bank_o  = cmd.bank;
  assign waddr_o = cmd.waddr;
  assign raddr_o = cmd.raddr;
endmodule

// File: rtl/tstreg_bank_store.sv
module tstreg_bank_store #(
  parameter int NB = 4,
  parameter int AW = 5,
  parameter int W  = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [$clog2(NB)-1:0] bank_i,
  input  logic [AW-1:0]         waddr_i,
  input  logic [W-1:0]          wdata_i,
  input  logic [AW-1:0]         raddr_i,
  output logic [W-1:0]          rdata_o
);
  localparam int DEPTH = 1 << AW;
  localparam int BW    = $clog2(NB);

  logic [W-1:0] bank_rd [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [W-1:0] mem_q [DEPTH];
    logic         sel;
    assign sel = we_i && (bank_i == BW'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (sel) begin
        mem_q[waddr_i] <= wdata_i;
      end
    end

    assign bank_rd[b] = mem_q[raddr_i];
  end

  assign rdata_o = bank_rd[bank_i];
endmodule

// File: rtl/tstreg_bridge.sv
module tstreg_bridge
  import tstreg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  input  logic              reg_we_i,
  output logic [15:0]       reg_rdata_o,
  output logic              hid_we_o,
  output logic [1:0]        hid_bank_o,
  output logic [4:0]        hid_addr_o,
  output logic [15:0]       hid_wdata_o
);
  logic [DW-1:0] ctrl_q, wdat_q, rdlo_q, rdhi_q;
  logic ctrl_we, other_we, bank_open;
  seq_e seq_state;
  logic do_wr, do_rd;
  logic [BANK_W-1:0]  cmd_bank;
  logic [BANK_AW-1:0] cmd_waddr, cmd_raddr;
  logic [DW-1:0]      bank_rdata;

  assign ctrl_we  = reg_we_i && (reg_addr_i == A_CTRL);
  assign other_we = reg_we_i && (reg_addr_i != A_CTRL);

  tstreg_unlock u_unlock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (ctrl_we),
    .other_we_i (other_we),
    .tm_i       (reg_wdata_i[10]),
    .open_o     (bank_open),
    .state_o    (seq_state)
  );

  tstreg_decode u_decode (
    .ctrl_we_i (ctrl_we),
    .wdata_i   (reg_wdata_i),
    .open_i    (bank_open),
    .do_wr_o   (do_wr),
    .do_rd_o   (do_rd),
    .bank_o    (cmd_bank),
    .waddr_o   (cmd_waddr),
    .raddr_o   (cmd_raddr)
  );

  tstreg_bank_store #(
    .NB (NBANK),
    .AW (BANK_AW),
    .W  (DW)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (do_wr),
    .bank_i  (cmd_bank),
    .waddr_i (cmd_waddr),
    .wdata_i (wdat_q),
    .raddr_i (cmd_raddr),
    .rdata_o (bank_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      wdat_q <= '0;
      rdlo_q <= '0;
      rdhi_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= reg_wdata_i & CTRL_KEEP;
      if (reg_we_i && reg_addr_i == A_WDAT) wdat_q <= reg_wdata_i;
      if (do_rd) begin
        rdlo_q <= bank_rdata;
        rdhi_q <= '0;
      end
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:  reg_rdata_o = ctrl_q;
      A_RDLO:  reg_rdata_o = rdlo_q;
      A_RDHI:  reg_rdata_o = rdhi_q;
      A_WDAT:  reg_rdata_o = wdat_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assign hid_we_o    = do_wr;
  assign hid_bank_o  = cmd_bank;
  assign hid_addr_o  = cmd_waddr;
  assign hid_wdata_o = wdat_q;
endmodule

// File: rtl/tstreg_bridge_sva.sv
module tstreg_bridge_sva
  import tstreg_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [4:0]  reg_addr_i,
  input logic [15:0] reg_wdata_i,
  input logic        reg_we_i,
  input logic [15:0] reg_rdata_o,
  input logic        hid_we_o,
  input logic        bank_open,
  input logic [15:0] rdlo_q,
  input seq_e        seq_state
);
  logic ctrl_wr;
  assign ctrl_wr = reg_we_i && reg_addr_i == A_CTRL;

  a_r2_open_after_tm1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bank_open) |-> $past(ctrl_wr && reg_wdata_i[10]));

  a_r3_stay_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_open && !(ctrl_wr && !reg_wdata_i[10])) |=> bank_open);

  a_r3_close_on_tm0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !reg_wdata_i[10]) |=> !bank_open);

  a_r4_strobe_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hid_we_o |-> (ctrl_wr && reg_wdata_i[14] && reg_wdata_i[10]));

  a_r6_strobe_needs_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hid_we_o |-> bank_open);

  a_r7_other_write_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i != A_CTRL && !bank_open) |=> seq_state == SEQ_IDLE);

  a_r8_write_keeps_rdlo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hid_we_o |=> $stable(rdlo_q));

  a_r5_rdhi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_RDHI) |-> reg_rdata_o == 16'h0000);
endmodule

bind tstreg_bridge tstreg_bridge_sva u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_we_i    (reg_we_i),
  .reg_rdata_o (reg_rdata_o),
  .hid_we_o    (hid_we_o),
  .bank_open   (bank_open),
  .rdlo_q      (rdlo_q),
  .seq_state   (seq_state)
);

// File: tb/tstreg_bridge_test.sv
module tstreg_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0;
  logic [15:0] rdata;
  logic        hid_we;
  logic [1:0]  hid_bank;
  logic [4:0]  hid_addr;
  logic [15:0] hid_wdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tstreg_bridge uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_we_i    (we),
    .reg_rdata_o (rdata),
    .hid_we_o    (hid_we),
    .hid_bank_o  (hid_bank),
    .hid_addr_o  (hid_addr),
    .hid_wdata_o (hid_wdata)
  );

  // reference model
  int          stage;          // 0..3 = steps seen, 4 = open
  logic [15:0] m_ctrl, m_wd, m_lo, m_hi;
  logic [15:0] m_mem [4][32];

  task automatic model_reset();
    stage = 0; m_ctrl = 0; m_wd = 0; m_lo = 0; m_hi = 0;
    for (int b = 0; b < 4; b++)
      for (int a = 0; a < 32; a++) m_mem[b][a] = 0;
  endtask

  function automatic logic [15:0] model_read(input logic [4:0] a);
    case (a)
      5'd20:   return m_ctrl;
      5'd21:   return m_lo;
      5'd22:   return m_hi;
      5'd23:   return m_wd;
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else if (we) begin
      if (addr == 5'd20) begin
        int b;
        logic ok, want;
        b = int'(wdata[12:11]);
        ok = (stage == 4) && wdata[10];
        if (ok && wdata[14]) m_mem[b][wdata[4:0]] = m_wd;
        else if (ok && wdata[15]) begin
          m_lo = m_mem[b][wdata[9:5]];
          m_hi = 0;
        end
        m_ctrl = wdata & 16'h3fff;
        want = (stage == 1 || stage == 3);
        if (stage == 4)            stage = wdata[10] ? 4 : 1;
        else if (wdata[10] == want) stage = stage + 1;
        else                        stage = wdata[10] ? 0 : 1;
      end else begin
        if (stage != 4) stage = 0;
        if (addr == 5'd23) m_wd = wdata;
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      logic exp_we;
      exp_we = we && addr == 5'd20 && stage == 4 && wdata[10] && wdata[14];
      check("R1 direct read", rdata, model_read(addr));
      check("R4 hid strobe", {15'h0, hid_we}, {15'h0, exp_we});
      if (exp_we) begin
        check("R4 hid bank", {14'h0, hid_bank}, {14'h0, wdata[12:11]});
        check("R4 hid addr", {11'h0, hid_addr}, {11'h0, wdata[4:0]});
        check("R4 hid data", hid_wdata, m_wd);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    we = 1'b0; addr = a;
    #2 d = rdata;
  endtask

  task automatic unlock();
    wr(5'h14, 16'h0000); wr(5'h14, 16'h0400);
    wr(5'h14, 16'h0000); wr(5'h14, 16'h0400);
  endtask

  task automatic hwrite(input int b, input int a, input logic [15:0] d);
    wr(5'h17, d);
    wr(5'h14, 16'h4400 | 16'(b << 11) | 16'(a));
  endtask

  task automatic hread(input int b, input int a, output logic [15:0] d);
    wr(5'h14, 16'h8400 | 16'(b << 11) | 16'(a << 5));
    rd(5'h15, d);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(5'h14, v); check("R10 ctrl after reset", v, 16'h0);
    rd(5'h15, v); check("R10 rdlo after reset", v, 16'h0);
    rd(5'h17, v); check("R10 wdat after reset", v, 16'h0);

    // R1 direct map
    wr(5'h17, 16'h1234); rd(5'h17, v); check("R1 wdat readback", v, 16'h1234);
    wr(5'h15, 16'hffff); rd(5'h15, v); check("R1 rdlo read-only", v, 16'h0);
    wr(5'h16, 16'hffff); rd(5'h16, v); check("R1 rdhi read-only", v, 16'h0);
    wr(5'h03, 16'hbeef); rd(5'h03, v); check("R1 unmapped reads 0", v, 16'h0);
    wr(5'h14, 16'hc417); rd(5'h14, v); check("R1 ctrl readback", v, 16'h0417);

    // R6 command while locked: written data must not land
    wr(5'h17, 16'h5555);
    wr(5'h14, 16'h4403);
    check("R6 no strobe locked", {15'h0, hid_we}, 16'h0);

    // R7 sequence broken by data-register write
    wr(5'h14, 16'h0000); wr(5'h14, 16'h0400);
    wr(5'h17, 16'h7777);
    wr(5'h14, 16'h0000); wr(5'h14, 16'h0400);
    wr(5'h14, 16'h4404);            // would be a write if open
    unlock();
    hread(0, 3, v); check("R6 locked write dropped", v, 16'h0);
    hread(0, 4, v); check("R7 broken unlock dropped", v, 16'h0);

    // R2 broken pattern 0,1,1 then valid
    wr(5'h14, 16'h0000);            // closes (R3)
    wr(5'h17, 16'h0001);            // restart
    wr(5'h14, 16'h0000); wr(5'h14, 16'h0400); wr(5'h14, 16'h0400);
    wr(5'h17, 16'h2222);
    wr(5'h14, 16'h4405);
    unlock();
    hread(0, 5, v); check("R2 bad pattern stays locked", v, 16'h0);

    // R4 / R9 writes into all banks
    hwrite(0, 23, 16'h8e0d);
    hwrite(3, 27, 16'h0005);
    hwrite(3, 29, 16'h029a);
    hwrite(3, 28, 16'haaaa);
    for (int b = 0; b < 4; b++) hwrite(b, 9, 16'h1000 + 16'(b));
    hwrite(1, 31, 16'hf00d);
    hwrite(2, 0, 16'h0bad);

    // R5 read-back and hi cleared
    hread(0, 23, v); check("R5 bank0 a23", v, 16'h8e0d);
    rd(5'h16, v);    check("R5 rdhi zero", v, 16'h0);
    hread(3, 27, v); check("R5 bank3 a27", v, 16'h0005);
    hread(3, 29, v); check("R5 bank3 a29", v, 16'h029a);
    hread(3, 28, v); check("R5 bank3 a28", v, 16'haaaa);
    for (int b = 0; b < 4; b++) begin
      hread(b, 9, v); check("R9 per-bank a9", v, 16'h1000 + 16'(b));
    end
    hread(1, 31, v); check("R9 bank1 a31", v, 16'hf00d);
    hread(2, 0, v);  check("R9 bank2 a0", v, 16'h0bad);
    hread(2, 31, v); check("R9 untouched location", v, 16'h0);

    // R5 timing: rdlo changes only after the command edge
    hread(0, 23, v);
    @(negedge clk);
    addr = 5'h14; wdata = 16'h8400 | 16'(3 << 11) | 16'(27 << 5); we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0; addr = 5'h15;
    #1 check("R5 rdlo after command", rdata, 16'h0005);

    // R8 both bits: write done, read ignored
    hread(3, 29, v);
    wr(5'h17, 16'hcafe);
    wr(5'h14, 16'hc400 | 16'(1 << 11) | 16'(31 << 5) | 16'd12);
    rd(5'h15, v);    check("R8 rdlo unchanged", v, 16'h029a);
    hread(1, 12, v); check("R8 write done", v, 16'hcafe);

    // R6 command with test-mode 0 while open closes, no effect
    wr(5'h17, 16'h9999);
    wr(5'h14, 16'h4006);
    check("R6 tm0 no strobe", {15'h0, hid_we}, 16'h0);
    wr(5'h14, 16'h4406);            // now locked (R3)
    wr(5'h17, 16'h0000);
    unlock();
    hread(0, 6, v); check("R3 closed by tm0", v, 16'h0);

    // R3 stays open through many writes
    for (int i = 0; i < 8; i++) hwrite(2, 10 + i, 16'h00a0 + 16'(i));
    for (int i = 0; i < 8; i++) begin
      hread(2, 10 + i, v); check("R3 still open", v, 16'h00a0 + 16'(i));
    end

    // R10 mid-run reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    hwrite(0, 23, 16'h1111);        // locked after reset
    rd(5'h17, v); check("R10 wdat holds new", v, 16'h1111);
    unlock();
    hread(0, 23, v); check("R10 hidden cleared", v, 16'h0);
    hread(3, 28, v); check("R10 bank3 cleared", v, 16'h0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule